// File: doc/BRIEF.md
# Tracking Angle Counter with Freezable Output Latch

This block is the digital back end of a tracking angle converter. An external closed loop reports shaft motion as single-cycle step pulses qualified by a direction bit. Each pulse moves an internal up/down position counter by one least significant bit, and the counter wraps modulo 2^WIDTH, so the angle runs on through the 0/360 degree point. The word is natural binary: the most significant bit carries 180 degrees and each lower bit half the weight of the bit above it.

The counter feeds an output latch through two cycle-count timers. Every accepted step arms a strobe delay and a busy window. When the strobe delay expires, the latch copies the counter. The busy flag covers the whole settling period, and data is safe to read while busy is low. An active-low inhibit stops steps from arming the timers, so the latch freezes while the counter keeps tracking. An active-low enable puts the latched word on the output bus. The bus is modelled as a data value plus an output-enable flag. STROBE_CYC must be smaller than BUSY_CYC.

Top module: `angle_latch_ctr`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the counter, the latch and both timers, and busy reads 0 afterwards.
- R2: A clock edge that samples step=1 changes the counter by +1 when step_up=1 and by -1 when step_up=0. An edge with step=0 leaves the counter unchanged.
- R3: The counter wraps modulo 2^WIDTH: a down step from 0 gives all ones, and an up step from all ones gives 0.
- R4: A step accepted at a clock edge while inhibit_n=1 makes the latch take the counter value STROBE_CYC edges later.
- R5: busy goes to 1 on the edge that accepts a step while inhibit_n=1. With no further accepted step, it stays 1 for exactly BUSY_CYC cycles and then returns to 0.
- R6: A step accepted while either timer is running restarts both timers. The latch therefore does not update during a burst of steps spaced closer than STROBE_CYC, and busy stays high throughout the burst.
- R7: Steps taken while inhibit_n=0 still move the counter but start neither timer: busy stays 0 and the latch holds its value. Releasing inhibit does not update the latch by itself.
- R8: A strobe already pending when inhibit_n falls still completes within the busy window. After that window the latch does not change while inhibit_n stays 0.
- R9: When enable_n=0, data_oe=1 and data_out equals the latch. When enable_n=1, data_oe=0 and data_out is 0. Toggling enable_n never changes the latch contents.
- R10: The latch changes only on cycles when busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | One-cycle step pulse from the tracking loop |
| step_up | input | 1 | Direction of the step: 1 counts up, 0 counts down |
| inhibit_n | input | 1 | Active-low freeze of latch updates |
| enable_n | input | 1 | Active-low output drive enable |
| busy | output | 1 | High while the counter and latch are settling |
| data_out | output | WIDTH | Latched angle word when driven, else 0 |
| data_oe | output | 1 | Output bus drive flag (1 = driven, 0 = high impedance) |

## Verification
The hardest case to reach is a strobe that is already pending at the moment inhibit falls, followed by further counting under inhibit. The bench issues one step, pulls inhibit low on the very next cycle, waits until the pending strobe must have fired, and then issues more steps. It checks that the latch holds the value captured by the pending strobe and ignores the later steps. It then releases inhibit and shows, through one further step, that the counter kept every hidden step.

// File: rtl/angle_latch_ctr.sv
module angle_latch_ctr #(
  parameter int WIDTH      = 12,
  parameter int STROBE_CYC = 8,
  parameter int BUSY_CYC   = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             step_up,
  input  logic             inhibit_n,
  input  logic             enable_n,
  output logic             busy,
  output logic [WIDTH-1:0] data_out,
  output logic             data_oe
);
  localparam int SW = $clog2(STROBE_CYC + 1);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [SW-1:0] S_LOAD = SW'(STROBE_CYC);
  localparam logic [BW-1:0] B_LOAD = BW'(BUSY_CYC);

  logic [WIDTH-1:0] count, latch_q;
  logic [SW-1:0]    strobe_cnt;
  logic [BW-1:0]    busy_cnt;
  logic             arm, fire;

  assign arm  = step & inhibit_n;
  assign fire = (strobe_cnt == SW'(1));

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (step)
      count <= step_up ? count + 1'b1 : count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_cnt <= '0;
      busy_cnt   <= '0;
    end else if (arm) begin
      strobe_cnt <= S_LOAD;
      busy_cnt   <= B_LOAD;
    end else begin
      if (strobe_cnt != '0) strobe_cnt <= strobe_cnt - 1'b1;
      if (busy_cnt != '0)   busy_cnt   <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      latch_q <= '0;
    else if (fire && !arm)
      latch_q <= count;
  end

  assign busy     = (busy_cnt != '0);
  assign data_oe  = ~enable_n;
  assign data_out = enable_n ? '0 : latch_q;
endmodule

// File: rtl/angle_latch_ctr_chk.sv
module angle_latch_ctr_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic             step_up,
  input logic             inhibit_n,
  input logic             enable_n,
  input logic             busy,
  input logic             data_oe,
  input logic [WIDTH-1:0] data_out,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] latch_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0 && latch_q == '0 && !busy));
  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (step && step_up) |=> count == $past(count) + 1'b1);
  a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
    (step && !step_up) |=> count == $past(count) - 1'b1);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));
  a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (step && inhibit_n) |=> busy);
  a_r7_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
    (!inhibit_n && !busy) |=> !busy);
  a_r10_latch_only_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(latch_q));
  a_r9_drive: assert property (@(posedge clk) disable iff (rst)
    !enable_n |-> (data_oe && data_out == latch_q));
  a_r9_float: assert property (@(posedge clk) disable iff (rst)
    enable_n |-> (!data_oe && data_out == '0));
endmodule

bind angle_latch_ctr angle_latch_ctr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .step(step), .step_up(step_up),
  .inhibit_n(inhibit_n), .enable_n(enable_n), .busy(busy),
  .data_oe(data_oe), .data_out(data_out), .count(count), .latch_q(latch_q)
);

// File: tb/sim_angle_latch_ctr.sv
module sim_angle_latch_ctr;
  localparam int W = 12;
  localparam int S = 8;
  localparam int B = 17;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk = 0, rst = 1, step = 0, step_up = 0, inhibit_n = 1, enable_n = 0;
  logic busy, data_oe;
  logic [W-1:0] data_out;
  logic [W-1:0] ref_cnt = '0;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  angle_latch_ctr #(.WIDTH(W), .STROBE_CYC(S), .BUSY_CYC(B)) u0 (
    .clk(clk), .rst(rst), .step(step), .step_up(step_up),
    .inhibit_n(inhibit_n), .enable_n(enable_n), .busy(busy),
    .data_out(data_out), .data_oe(data_oe));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_step(input logic up);
    step = 1; step_up = up;
    @(negedge clk);
    step = 0;
    ref_cnt = up ? ref_cnt + 1'b1 : ref_cnt - 1'b1;
  endtask

  task automatic t_reset;
    rst = 1; wait_n(2); rst = 0; wait_n(1);
    ref_cnt = '0;
    check("R1 latch", int'(data_out), 0);
    check("R1 busy", int'(busy), 0);
  endtask

  task automatic t_single;
    logic [W-1:0] prev;
    prev = data_out;
    do_step(1);
    check("R5 busy rise", int'(busy), 1);
    wait_n(S - 1);
    check("R4 before strobe", int'(data_out), int'(prev));
    wait_n(1);
    check("R4 after strobe", int'(data_out), int'(ref_cnt));
    wait_n(B - S - 1);
    check("R5 busy last", int'(busy), 1);
    wait_n(1);
    check("R5 busy fall", int'(busy), 0);
  endtask

  task automatic t_wrap;
    while (ref_cnt != '0) do_step(0);
    wait_n(B + 1);
    do_step(0);
    wait_n(B + 1);
    check("R3 down wrap", int'(data_out), int'(ALL1));
    do_step(1);
    wait_n(B + 1);
    check("R3 up wrap", int'(data_out), 0);
    do_step(1); do_step(1); do_step(0);
    wait_n(B + 1);
    check("R2 up up down", int'(data_out), 1);
  endtask

  task automatic t_burst;
    logic [W-1:0] prev;
    int busy_low = 0, moved = 0;
    prev = data_out;
    for (int k = 0; k < 6; k++) begin
      do_step(1);
      if (!busy) busy_low++;
      if (data_out != prev) moved++;
      wait_n(2);
      if (!busy) busy_low++;
      if (data_out != prev) moved++;
    end
    check("R6 busy held", busy_low, 0);
    check("R6 no mid update", moved, 0);
    wait_n(B);
    check("R6 final latch", int'(data_out), int'(ref_cnt));
    check("R6 busy settled", int'(busy), 0);
  endtask

  task automatic t_inhibit;
    logic [W-1:0] prev;
    int busy_hi = 0;
    prev = data_out;
    inhibit_n = 0; wait_n(1);
    for (int k = 0; k < 10; k++) begin
      do_step(1);
      if (busy) busy_hi++;
    end
    wait_n(B + 2);
    check("R7 busy idle", busy_hi + int'(busy), 0);
    check("R7 latch held", int'(data_out), int'(prev));
    inhibit_n = 1; wait_n(B + 2);
    check("R7 release no strobe", int'(data_out), int'(prev));
    do_step(0);
    wait_n(S);
    check("R7 counter tracked", int'(data_out), int'(ref_cnt));
    wait_n(B);
  endtask

  task automatic t_pending;
    logic [W-1:0] cap;
    step = 1; step_up = 1;
    @(negedge clk);
    step = 0; ref_cnt = ref_cnt + 1'b1; cap = ref_cnt;
    inhibit_n = 0;
    wait_n(S + 1);
    check("R8 pending strobe done", int'(data_out), int'(cap));
    do_step(1); do_step(1); do_step(1);
    wait_n(B + 2);
    check("R8 frozen after window", int'(data_out), int'(cap));
    check("R8 busy low", int'(busy), 0);
    inhibit_n = 1; wait_n(1);
    do_step(1);
    wait_n(S);
    check("R8 hidden steps kept", int'(data_out), int'(ref_cnt));
    wait_n(B);
  endtask

  task automatic t_enable;
    logic [W-1:0] prev;
    prev = data_out;
    enable_n = 1; wait_n(1);
    check("R9 float oe", int'(data_oe), 0);
    check("R9 float data", int'(data_out), 0);
    wait_n(3);
    enable_n = 0; wait_n(1);
    check("R9 drive oe", int'(data_oe), 1);
    check("R9 drive data", int'(data_out), int'(prev));
  endtask

  task automatic t_mid_reset;
    do_step(1); do_step(1);
    rst = 1; wait_n(1); rst = 0; wait_n(1);
    ref_cnt = '0;
    check("R1 mid busy", int'(busy), 0);
    check("R1 mid latch", int'(data_out), 0);
    do_step(1);
    wait_n(S);
    check("R1 counter cleared", int'(data_out), 1);
    ref_cnt = 1;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_burst();
    t_inhibit();
    t_pending();
    t_enable();
    t_mid_reset();
    wait_n(B + 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule